// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed 16-bit two's complement operands and delivers the exact 32-bit signed product. The multiplier operand is recoded two bits at a time into radix-4 digits from the set {-2, -1, 0, +1, +2}. A chain of eight adder stages then folds the multiplicand into a running partial sum. Each stage settles two final low-order product bits, and it hands the rest of its sum, arithmetically shifted right by two, to the next stage. The last stage's shifted sum forms the upper half of the product.

A negative digit is applied by adding the one's complement of the chosen addend with a carry-in of one. Doubling is a one-bit left shift of the multiplicand. Each stage adder is two bits wider than the operand, so the true sign of every sum is kept and the extension into the shifted partial sum is exact. A parameter selects whether the product leaves through a register, with one cycle of latency and a synchronous active-high reset, or leaves straight from the adder chain.

Top module: `booth_mult16`

## Requirements
- R1: For every pair of signed operands `a` and `b`, `p` equals the exact signed product a*b as a 32-bit two's complement value.
- R2: Digit k (k = 0..7) is recoded from `a` bits [2k+1:2k-1], with a zero standing in for bit -1. The triples 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. Alternating, repeated and all-ones bit patterns in `a` give exact products.
- R3: `a` = -32768 and `b` = -32768 give `p` = 0x40000000.
- R4: The most negative operand times the most positive operand gives 0xC0008000, in either operand order.
- R5: If either operand is zero, `p` is zero.
- R6: `b` = 1 gives `p` equal to `a` sign-extended to 32 bits, and `b` = -1 gives the 32-bit negation of `a`.
- R7: For nonzero operands, `p[31]` equals `a[15]` XOR `b[15]`.
- R8: With the output register enabled, `p` shows the product of the operands sampled at the previous rising edge. A cycle with `rst` high leaves `p` at zero on the next edge, whatever the operands are in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 16 | Signed multiplier operand, the operand that is Booth-recoded |
| b | input | 16 | Signed multiplicand operand |
| p | output | 32 | Signed product |

## Verification
Two functions can act in the same cycle. The synchronous reset can arrive in the cycle in which new operands are presented, and the most negative operand can reach the top digit's subtract-double path while the multiplicand is also the most negative value. The bench raises `rst` while it drives -32768 on both operands and expects zero on the next edge. It then drives the same pair with reset low and expects 0x40000000. A scoreboard queue holds the expected value for each cycle, and each value is compared at the port one edge later.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [2:0] {
    DG_ZERO = 3'd0,
    DG_P1   = 3'd1,
    DG_P2   = 3'd2,
    DG_M2   = 3'd3,
    DG_M1   = 3'd4
  } digit_t;

  typedef struct packed {
    logic use_b;
    logic dbl;
    logic neg;
  } addsel_t;

  function automatic digit_t recode(input logic [2:0] trip);
    digit_t d;
    case (trip)
      3'b001, 3'b010: d = DG_P1;
      3'b011:         d = DG_P2;
      3'b100:         d = DG_M2;
      3'b101, 3'b110: d = DG_M1;
      default:        d = DG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0] trip,
  output addsel_t    sel
);

  digit_t dig;

  always_comb begin
    dig = recode(trip);
    sel = '0;
    case (dig)
      DG_P1:   sel = '{use_b: 1'b1, dbl: 1'b0, neg: 1'b0};
      DG_P2:   sel = '{use_b: 1'b1, dbl: 1'b1, neg: 1'b0};
      DG_M2:   sel = '{use_b: 1'b1, dbl: 1'b1, neg: 1'b1};
      DG_M1:   sel = '{use_b: 1'b1, dbl: 1'b0, neg: 1'b1};
      default: sel = '0;
    endcase
  end

  // R2: a zero digit never requests a subtraction
  always_comb begin
    if (!sel.use_b) begin
      p_zero_not_neg_r2: assert (!sel.neg && !sel.dbl);
    end
  end

endmodule

// File: rtl/booth_stage.sv
module booth_stage
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] ps_in,
  input  logic [W-1:0] mcand,
  input  logic [2:0]   trip,
  output logic [1:0]   pbits,
  output logic [W-1:0] ps_out
);

  localparam int EW = W + 2;

  addsel_t        sel;
  logic [EW-1:0]  ext_one;
  logic [EW-1:0]  ext_two;
  logic [EW-1:0]  mag;
  logic [EW-1:0]  addend;
  logic [EW-1:0]  ps_ext;
  logic [EW-1:0]  sum;

  booth_recoder u_rec (
    .trip (trip),
    .sel  (sel)
  );

  always_comb begin
    ext_one = {{2{mcand[W-1]}}, mcand};
    ext_two = {mcand[W-1], mcand, 1'b0};
    if (!sel.use_b)   mag = '0;
    else if (sel.dbl) mag = ext_two;
    else              mag = ext_one;
    addend = sel.neg ? ~mag : mag;
    ps_ext = {{2{ps_in[W-1]}}, ps_in};
    sum    = ps_ext + addend + EW'(sel.neg);
    pbits  = sum[1:0];
    ps_out = sum[EW-1:2];
  end

endmodule

// File: rtl/booth_mult16.sv
module booth_mult16 #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);

  localparam int STAGES = WIDTH / 2;
  localparam int PW     = 2 * WIDTH;

  logic [WIDTH:0]       a_pad;
  logic [WIDTH-1:0]     ps [STAGES+1];
  logic [1:0]           pb [STAGES];
  logic [WIDTH-1:0]     lo;
  logic [PW-1:0]        prod_c;

  assign a_pad = {a, 1'b0};
  assign ps[0] = '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    booth_stage #(.W(WIDTH)) u_stage (
      .ps_in  (ps[k]),
      .mcand  (b),
      .trip   (a_pad[2*k+2:2*k]),
      .pbits  (pb[k]),
      .ps_out (ps[k+1])
    );
  end

  always_comb begin
    lo = '0;
    for (int k = 0; k < STAGES; k++) begin
      lo[2*k +: 2] = pb[k];
    end
    prod_c = {ps[STAGES], lo};
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) p <= '0;
      else     p <= prod_c;
    end

    localparam logic [WIDTH-1:0] S_MIN   = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] S_MAX   = ~S_MIN;
    localparam logic [PW-1:0]    ONE_P   = 1;
    localparam logic [PW-1:0]    P_MINSQ = ONE_P << (PW - 2);
    localparam logic [PW-1:0]    P_MINMX = (~P_MINSQ + ONE_P) + (ONE_P << (WIDTH - 1));

    // R5: a zero operand gives a zero product
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (a == '0 || b == '0) |=> (p == '0));

    // R7: sign of a nonzero product
    p_sign_r7: assert property (@(posedge clk) disable iff (rst)
      (a != '0 && b != '0) |=> (p[PW-1] == $past(a[WIDTH-1] ^ b[WIDTH-1])));

    // R6: multiplying by one reproduces the sign-extended multiplier
    p_ident_r6: assert property (@(posedge clk) disable iff (rst)
      (b == ONE_P[WIDTH-1:0]) |=> (p == {{WIDTH{$past(a[WIDTH-1])}}, $past(a)}));

    // R3: most negative squared
    p_minsq_r3: assert property (@(posedge clk) disable iff (rst)
      (a == S_MIN && b == S_MIN) |=> (p == P_MINSQ));

    // R4: most negative times most positive
    p_minmax_r4: assert property (@(posedge clk) disable iff (rst)
      ((a == S_MIN && b == S_MAX) || (a == S_MAX && b == S_MIN)) |=> (p == P_MINMX));
  end else begin : g_comb
    assign p = prod_c;
  end

endmodule

// File: tb/booth_mult16_tb.sv
module booth_mult16_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [31:0] p;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t q[$];

  booth_mult16 #(.WIDTH(16), .OUT_REG(1'b1)) u_dut (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .p   (p)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic drive(input logic [15:0] x, input logic [15:0] y, input string tag);
    item_t it;
    longint ex;
    @(negedge clk);
    a = x;
    b = y;
    ex = longint'($signed(x)) * longint'($signed(y));
    it.exp = ex[31:0];
    it.tag = tag;
    it.due = cyc + 1;
    q.push_back(it);
  endtask

  // monitor: compares the port against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (p !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, p, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  localparam logic [15:0] CORNER [7] = '{16'h0000, 16'h0001, 16'hFFFF,
                                         16'h7FFF, 16'h8000, 16'h0002, 16'hFFFE};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (p !== 32'h0) begin
      bad++;
      $display("FAIL R8 reset state actual=%h expected=%h", p, 32'h0);
    end
    rst = 1'b0;

    // R3 / R4 extreme pairs
    drive(16'h8000, 16'h8000, "R3");
    drive(16'h8000, 16'h7FFF, "R4");
    drive(16'h7FFF, 16'h8000, "R4");

    // R5 zero operands
    drive(16'h0000, 16'h8000, "R5");
    drive(16'h1234, 16'h0000, "R5");

    // R6 identity and negation
    drive(16'h8000, 16'h0001, "R6");
    drive(16'hBEEF, 16'h0001, "R6");
    drive(16'h1357, 16'hFFFF, "R6");
    drive(16'h8000, 16'hFFFF, "R6");

    // R2 digit patterns in the recoded operand
    foreach (CORNER[i]) begin
      drive(16'h5555, 16'd12345, "R2");
      drive(16'hAAAA, 16'hFCFD, "R2");
      drive(16'h3333, CORNER[i], "R2");
      drive(16'hCCCC, CORNER[i], "R2");
      drive(16'hFFFF, CORNER[i], "R2");
    end

    // R7 mixed signs
    drive(16'hFF00, 16'h0100, "R7");
    drive(16'h0100, 16'hFF00, "R7");
    drive(16'hFF00, 16'hFF00, "R7");

    // R1 all corner pairs
    foreach (CORNER[i]) begin
      foreach (CORNER[j]) begin
        drive(CORNER[i], CORNER[j], "R1");
      end
    end

    // R8 reset arriving with extreme operands in the same cycle
    begin
      item_t it;
      @(negedge clk);
      rst = 1'b1;
      a = 16'h8000;
      b = 16'h8000;
      it.exp = 32'h0;
      it.tag = "R8";
      it.due = cyc + 1;
      q.push_back(it);
    end
    @(negedge clk);
    rst = 1'b0;
    drive(16'h8000, 16'h8000, "R8");

    // R1 random vectors
    for (int n = 0; n < 400; n++) begin
      drive(16'($urandom), 16'($urandom), "R1");
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule